// File: doc/BRIEF.md
# True-Color Pixel Expander

This block takes one true-color pixel word per clock and turns it into three 8-bit color channels and an 8-bit overlay index for the DAC stage. Four word formats are accepted. Two are 16-bit formats with short color fields: 1-5-5-5 with a single overlay bit, and 5-6-5 with no overlay. Two are 32-bit formats with full 8-bit colors and an overlay byte, and the second of these stores its fields in the opposite order from the first. Short color fields are placed at the top of their channel and the low bits are filled with zeros.

For every pixel the block also chooses between the true-color data and the overlay palette path. It builds an 8-bit overlay value. In the 1-5-5-5 format the seven upper bits of that value come from a palette-page register. The value is then ANDed with a read mask. The true-color channels are used only when the masked value is zero. Otherwise the channels are held at zero and the masked overlay value is passed on as the palette index. The palette lookup itself is not part of this block. The format select is sampled with each pixel, and all outputs are registered with one cycle of latency.

Top module: `tcx_expander`

## Requirements
- R1: While rst_n is low, every output is zero and out_true is low, whatever the inputs are.
- R2: When fmt_sel = 0 (1-5-5-5), red is pix_word[14:10], green is pix_word[9:5] and blue is pix_word[4:0]. Each field goes into bits 7:3 of its channel and bits 2:0 are 0.
- R3: When fmt_sel = 1 (5-6-5), red is pix_word[15:11] and goes to bits 7:3 of its channel. Green is pix_word[10:5] and goes to bits 7:2. Blue is pix_word[4:0] and goes to bits 7:3. All remaining low bits are 0.
- R4: When fmt_sel = 0, the overlay value is {page_reg[7:1], pix_word[15]}.
- R5: When fmt_sel = 2, the overlay is pix_word[31:24], red is [23:16], green is [15:8] and blue is [7:0].
- R6: When fmt_sel = 3, blue is pix_word[31:24], green is [23:16], red is [15:8] and the overlay is [7:0].
- R7: out_ovl carries the overlay value ANDed with read_mask.
- R8: out_true is high exactly when the masked overlay value is zero. When it is high, the channels carry the expanded colors. When it is low, all three channels are 0.
- R9: If read_mask is zero, out_true is high and the true-color channels are output, in every format and for every palette page.
- R10: When fmt_sel = 1, the overlay value is zero. The true-color path is therefore always selected, whatever page_reg and read_mask are.
- R11: Each output reflects the inputs sampled at the previous rising clock edge. fmt_sel may change on every pixel, and each pixel is decoded with the format sampled alongside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_word | input | 32 | True-color pixel word (16-bit formats use bits 15:0) |
| fmt_sel | input | 2 | Format: 0 = 1-5-5-5, 1 = 5-6-5, 2 = 8-8-8 overlay high, 3 = 8-8-8 reversed |
| page_reg | input | 8 | Palette page; bits 7:1 pad the overlay in 1-5-5-5 |
| read_mask | input | 8 | Mask ANDed with the overlay value |
| out_red | output | 8 | Red channel |
| out_grn | output | 8 | Green channel |
| out_blu | output | 8 | Blue channel |
| out_ovl | output | 8 | Masked overlay value, used as the palette index |
| out_true | output | 1 | High when the true-color path drives the channels |

## Verification
In the 1-5-5-5 format, the padding of the overlay with the palette page and the read-mask gate act on the same pixel in the same cycle. An error in either one changes which path is selected. The bench provokes this coincidence by sweeping pairs of palette page and mask, with the word's overlay bit both set and clear. It judges the result from out_true, out_ovl and the zeroed channels against an arithmetic model. Format changes on every cycle, mixed with long per-format sweeps, show that each pixel is decoded with its own format in the cycle after it is presented.

// File: rtl/tcx_pkg.sv
package tcx_pkg;

    // Width of one color channel and of the overlay value.
    localparam int CH_W    = 8;
    // Short color field width used by the 16-bit formats.
    localparam int SHORT_W = 5;
    // Wide green field width used by the 5-6-5 format.
    localparam int MID_W   = 6;
    // Number of byte lanes in a wide word.
    localparam int LANES   = 4;
    localparam int WORD_W  = CH_W * LANES;
    localparam int HALF_W  = 16;

    typedef enum logic [1:0] {
        FMT_1555    = 2'd0,
        FMT_565     = 2'd1,
        FMT_WIDE_HI = 2'd2,
        FMT_WIDE_RV = 2'd3
    } fmt_e;

    typedef struct packed {
        logic [CH_W-1:0] red;
        logic [CH_W-1:0] grn;
        logic [CH_W-1:0] blu;
        logic [CH_W-1:0] ovl;
    } fields_t;

    typedef struct packed {
        logic [CH_W-1:0] red;
        logic [CH_W-1:0] grn;
        logic [CH_W-1:0] blu;
        logic [CH_W-1:0] ovl;
        logic            tru;
    } pix_out_t;

endpackage

// File: rtl/tcx_short_unpack.sv
// Unpacks a 16-bit word with short color fields. G_W selects the green
// width: equal to the short width gives the 1-5-5-5 layout with an overlay
// bit on top, wider gives the 5-6-5 layout with no overlay bit.
module tcx_short_unpack
    import tcx_pkg::*;
#(
    parameter int G_W = SHORT_W
) (
    input  logic [HALF_W-1:0] half_word,
    output logic [CH_W-1:0]   red_x,
    output logic [CH_W-1:0]   grn_x,
    output logic [CH_W-1:0]   blu_x,
    output logic              ovl_bit
);
    localparam int B_LO = 0;
    localparam int G_LO = SHORT_W;
    localparam int R_LO = SHORT_W + G_W;
    localparam int R_HI = R_LO + SHORT_W - 1;
    localparam int S_PAD = CH_W - SHORT_W;
    localparam int G_PAD = CH_W - G_W;

    always_comb begin
        red_x = {half_word[R_HI:R_LO], {S_PAD{1'b0}}};
        grn_x = {half_word[R_LO-1:G_LO], {G_PAD{1'b0}}};
        blu_x = {half_word[G_LO-1:B_LO], {S_PAD{1'b0}}};
    end

    generate
        if (R_HI < HALF_W - 1) begin : g_with_ovl
            assign ovl_bit = half_word[HALF_W-1];
        end else begin : g_no_ovl
            assign ovl_bit = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/tcx_wide_unpack.sv
// Splits a 32-bit word into byte lanes and assigns them to the overlay and
// the three colors. REVERSED picks the mirrored field order.
module tcx_wide_unpack
    import tcx_pkg::*;
#(
    parameter bit REVERSED = 1'b0
) (
    input  logic [WORD_W-1:0] word,
    output fields_t           fields
);
    logic [CH_W-1:0] lane [LANES];

    genvar k;
    generate
        for (k = 0; k < LANES; k++) begin : g_lane
            assign lane[k] = word[k*CH_W +: CH_W];
        end

        if (REVERSED) begin : g_rev
            always_comb begin
                fields.blu = lane[3];
                fields.grn = lane[2];
                fields.red = lane[1];
                fields.ovl = lane[0];
            end
        end else begin : g_fwd
            always_comb begin
                fields.ovl = lane[3];
                fields.red = lane[2];
                fields.grn = lane[1];
                fields.blu = lane[0];
            end
        end
    endgenerate

endmodule

// File: rtl/tcx_overlay_gate.sv
// Masks the overlay value and decides which path drives the channels.
module tcx_overlay_gate
    import tcx_pkg::*;
(
    input  fields_t         fields,
    input  logic [CH_W-1:0] mask,
    output pix_out_t        result
);
    logic [CH_W-1:0] masked;
    logic            use_true;

    always_comb begin
        masked   = fields.ovl & mask;
        use_true = (masked == '0);

        result.ovl = masked;
        result.tru = use_true;
        if (use_true) begin
            result.red = fields.red;
            result.grn = fields.grn;
            result.blu = fields.blu;
        end else begin
            result.red = '0;
            result.grn = '0;
            result.blu = '0;
        end
    end

endmodule

// File: rtl/tcx_expander.sv
module tcx_expander
    import tcx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] pix_word,
    input  logic [1:0]        fmt_sel,
    input  logic [CH_W-1:0]   page_reg,
    input  logic [CH_W-1:0]   read_mask,
    output logic [CH_W-1:0]   out_red,
    output logic [CH_W-1:0]   out_grn,
    output logic [CH_W-1:0]   out_blu,
    output logic [CH_W-1:0]   out_ovl,
    output logic              out_true
);
    fields_t  f1555, f565, fhi, frv, pick;
    pix_out_t gated;
    pix_out_t pix_d, pix_q;
    logic     bit1555;
    logic     bit565_unused;
    logic     page_lsb_unused;

    assign page_lsb_unused = page_reg[0];

    tcx_short_unpack #(.G_W(SHORT_W)) u_s1555 (
        .half_word (pix_word[HALF_W-1:0]),
        .red_x     (f1555.red),
        .grn_x     (f1555.grn),
        .blu_x     (f1555.blu),
        .ovl_bit   (bit1555)
    );
    assign f1555.ovl = {page_reg[CH_W-1:1], bit1555};

    tcx_short_unpack #(.G_W(MID_W)) u_s565 (
        .half_word (pix_word[HALF_W-1:0]),
        .red_x     (f565.red),
        .grn_x     (f565.grn),
        .blu_x     (f565.blu),
        .ovl_bit   (bit565_unused)
    );
    assign f565.ovl = '0;

    tcx_wide_unpack #(.REVERSED(1'b0)) u_whi (
        .word   (pix_word),
        .fields (fhi)
    );

    tcx_wide_unpack #(.REVERSED(1'b1)) u_wrv (
        .word   (pix_word),
        .fields (frv)
    );

    always_comb begin
        unique case (fmt_e'(fmt_sel))
            FMT_1555:    pick = f1555;
            FMT_565:     pick = f565;
            FMT_WIDE_HI: pick = fhi;
            default:     pick = frv;
        endcase
    end

    tcx_overlay_gate u_gate (
        .fields (pick),
        .mask   (read_mask),
        .result (gated)
    );

    always_comb begin
        pix_d = gated;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_q <= '0;
        end else begin
            pix_q <= pix_d;
        end
    end

    assign out_red  = pix_q.red;
    assign out_grn  = pix_q.grn;
    assign out_blu  = pix_q.blu;
    assign out_ovl  = pix_q.ovl;
    assign out_true = pix_q.tru;

endmodule

// File: rtl/tcx_expander_chk.sv
module tcx_expander_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  fmt_sel,
    input logic [7:0]  page_reg,
    input logic [7:0]  read_mask,
    input logic [7:0]  out_red,
    input logic [7:0]  out_grn,
    input logic [7:0]  out_blu,
    input logic [7:0]  out_ovl,
    input logic        out_true
);
    logic seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    AST_PAL_ZERO_RGB: assert property (@(posedge clk) disable iff (!rst_n)
        !out_true |-> (out_red == 8'd0 && out_grn == 8'd0 && out_blu == 8'd0)); // R8

    AST_TRUE_OVL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_true |-> (out_ovl == 8'd0)); // R7

    AST_MASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(read_mask) == 8'd0) |-> out_true); // R9

    AST_565_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(fmt_sel) == 2'd1) |->
            (out_true && out_red[2:0] == 3'd0 && out_grn[1:0] == 2'd0
             && out_blu[2:0] == 3'd0)); // R3

    AST_1555_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(fmt_sel) == 2'd0) |->
            (out_ovl[7:1] == ($past(page_reg[7:1]) & $past(read_mask[7:1])))); // R4

    AST_1555_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(fmt_sel) == 2'd0) |->
            (out_red[2:0] == 3'd0 && out_grn[2:0] == 3'd0
             && out_blu[2:0] == 3'd0)); // R2

endmodule

bind tcx_expander tcx_expander_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fmt_sel   (fmt_sel),
    .page_reg  (page_reg),
    .read_mask (read_mask),
    .out_red   (out_red),
    .out_grn   (out_grn),
    .out_blu   (out_blu),
    .out_ovl   (out_ovl),
    .out_true  (out_true)
);

// File: tb/sim_tcx_expander.sv
`timescale 1ns/1ps
module sim_tcx_expander;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pix_word = '0;
    logic [1:0]  fmt_sel = '0;
    logic [7:0]  page_reg = '0;
    logic [7:0]  read_mask = '0;
    logic [7:0]  out_red, out_grn, out_blu, out_ovl;
    logic        out_true;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    tcx_expander u0 (
        .clk(clk), .rst_n(rst_n), .pix_word(pix_word), .fmt_sel(fmt_sel),
        .page_reg(page_reg), .read_mask(read_mask),
        .out_red(out_red), .out_grn(out_grn), .out_blu(out_blu),
        .out_ovl(out_ovl), .out_true(out_true)
    );

    // Reference model written from the requirements.
    function automatic logic [32:0] model(input logic [31:0] w, input logic [1:0] f,
                                          input logic [7:0] pg, input logic [7:0] mk);
        logic [7:0] r, g, b, ov, m;
        logic t;
        case (f)
            2'd0: begin
                r = {w[14:10], 3'b000}; g = {w[9:5], 3'b000};
                b = {w[4:0], 3'b000};   ov = {pg[7:1], w[15]};
            end
            2'd1: begin
                r = {w[15:11], 3'b000}; g = {w[10:5], 2'b00};
                b = {w[4:0], 3'b000};   ov = 8'd0;
            end
            2'd2: begin
                ov = w[31:24]; r = w[23:16]; g = w[15:8]; b = w[7:0];
            end
            default: begin
                b = w[31:24]; g = w[23:16]; r = w[15:8]; ov = w[7:0];
            end
        endcase
        m = ov & mk;
        t = (m == 8'd0);
        if (!t) begin r = 8'd0; g = 8'd0; b = 8'd0; end
        return {r, g, b, m, t};
    endfunction

    task automatic step(input logic [31:0] w, input logic [1:0] f,
                        input logic [7:0] pg, input logic [7:0] mk, input string tag);
        logic [32:0] exp_v, got;
        @(negedge clk);
        pix_word = w; fmt_sel = f; page_reg = pg; read_mask = mk;
        exp_v = model(w, f, pg, mk);
        @(posedge clk);
        #1;
        got = {out_red, out_grn, out_blu, out_ovl, out_true};
        total++;
        if (got !== exp_v) begin
            bad++;
            $display("FAIL %s fmt=%0d word=%h page=%h mask=%h actual=%h expected=%h",
                     tag, f, w, pg, mk, got, exp_v);
        end
    endtask

    initial begin : watchdog
        #1900000;
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] lf;
        // R1: outputs stay zero under reset with busy inputs.
        pix_word = 32'hFFFF_FFFF; fmt_sel = 2'd2; page_reg = 8'hFF; read_mask = 8'hFF;
        repeat (3) @(posedge clk);
        #1;
        total++;
        if ({out_red, out_grn, out_blu, out_ovl, out_true} !== 33'd0) begin
            bad++;
            $display("FAIL R1 actual=%h expected=0",
                     {out_red, out_grn, out_blu, out_ovl, out_true});
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R2, R4, R8: every 1-5-5-5 word, page and mask varying.
        for (int i = 0; i < 65536; i++)
            step(i[31:0], 2'd0, 8'(i * 37), ((i & 3) == 0) ? 8'h01 : 8'hFF, "R2");

        // R3, R10: 5-6-5 words with arbitrary page and mask.
        for (int i = 0; i < 65536; i += 3)
            step(i[31:0], 2'd1, 8'(i), 8'(i >> 5) | 8'h80, "R3");

        // R5, R6, R7: pseudo-random wide words, masks chosen to hit both paths.
        lf = 32'h1234_5678;
        for (int i = 0; i < 20000; i++) begin
            lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
            step((i % 5 == 0) ? (lf & 32'h00FF_FF00) : lf, 2'd2, 8'hAA,
                 8'(lf >> 3), "R5");
            step((i % 5 == 0) ? (lf & 32'hFFFF_FF00) : lf, 2'd3, 8'h55,
                 8'(lf >> 11), "R6");
        end

        // R4, R7, R8: page x mask sweep with overlay bit set and clear.
        for (int pg = 0; pg < 256; pg++)
            for (int mk = 0; mk < 256; mk += 4)
                step({16'h0, ((pg + mk) & 1) ? 1'b1 : 1'b0, 15'h5AB3},
                     2'd0, 8'(pg), 8'(mk | (pg & 1)), "R7");

        // R9: zero mask forces the true-color path in every format.
        for (int f = 0; f < 4; f++)
            for (int pg = 0; pg < 256; pg += 17)
                step(32'hFFFF_FFFF ^ (pg << 9), f[1:0], 8'(pg), 8'h00, "R9");

        // R11: format changes every pixel.
        lf = 32'hCAFE_F00D;
        for (int i = 0; i < 4000; i++) begin
            lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
            step(lf, 2'(i ^ (i >> 2)), 8'(lf >> 8), 8'(lf >> 24) & 8'hF3, "R11");
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule